// File: doc/BRIEF.md
# DRAM RAS/CAS Strobe Sequencer

This block drives the row and column strobes of a fast-page-mode or EDO DRAM for read/write accesses and for RAS-only refresh cycles. All intervals are counted in half memory-clock periods. `clk_i` runs at twice the memory clock and has a duty cycle close to 50%. Each rising edge of `clk_i` is one half-period tick, so settings of 1.5 clocks can be produced with outputs that are all registered and free of glitches.

A cycle begins when a request is pending at a cycle boundary. RAS# falls first. The row-to-column delay runs next, and the address select switches to the column one tick before CAS# falls. CAS# stays low for its width, then RAS# and CAS# rise together. The precharge interval follows. At its end `done_o` pulses for one tick. If a request is still pending, the next cycle's RAS# falls on that same tick; if not, the sequencer goes idle. The delay select, precharge select and DRAM type are latched when RAS# falls, and they govern that whole cycle including its precharge.

Top module: `dram_ras_cas_seq`

## Requirements
- R1: During and after reset with no request, `ras_n_o` and `cas_n_o` are 1, and `col_sel_o` and `done_o` are 0.
- R2: For an access, CAS# falls 4 ticks after RAS# when `rcd_sel_i` is 0, and 2 ticks after RAS# when it is 1.
- R3: With `edo_i`=1 and `rp_sel_i`=01, the RAS#-to-CAS# delay is 4 ticks whatever `rcd_sel_i` is.
- R4: For accesses, the RAS# high time between back-to-back cycles is 4 ticks for `rp_sel_i`=00, 3 for 01 and 2 for 10.
- R5: The reserved code `rp_sel_i`=11 behaves exactly like 00.
- R6: A refresh with `edo_i`=0 and a precharge code other than 01 gets one extra tick of precharge. EDO refreshes and all accesses use the plain value.
- R7: CAS# stays low for 2 ticks, or 3 ticks when the precharge code is 01. It rises on the same tick as RAS#, and it is never low while RAS# is high.
- R8: During a refresh cycle CAS# stays high and `col_sel_o` stays 0. RAS# is low for the delay plus the CAS# width that an access with the same settings would use.
- R9: `col_sel_o` rises one tick before CAS# falls and returns to 0 when RAS# rises.
- R10: When `refresh_req_i` and `access_req_i` are both pending at a boundary, a refresh cycle is started.
- R11: A change of `rcd_sel_i`, `rp_sel_i` or `edo_i` after RAS# falls does not change the timing of that cycle, its precharge included.
- R12: `done_o` is high for exactly one tick, on the tick that ends precharge. A pending request starts its RAS# fall on that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Half-period tick clock (twice the memory clock) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| access_req_i | input | 1 | Level request for a read/write cycle |
| refresh_req_i | input | 1 | Level request for a RAS-only refresh cycle |
| edo_i | input | 1 | DRAM type: 1 = EDO, 0 = fast page mode |
| rcd_sel_i | input | 1 | Row-to-column delay: 0 = 2 clocks, 1 = 1 clock |
| rp_sel_i | input | 2 | Precharge: 00 = 2, 01 = 1.5, 10 = 1 clock, 11 = as 00 |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| col_sel_o | output | 1 | Address phase: 0 = row, 1 = column |
| done_o | output | 1 | One-tick pulse at the end of precharge |

## Verification
Two events can land on the same tick: the end of one cycle's precharge with its `done_o` pulse, and the launch of the next cycle with its RAS# fall and a fresh latch of the configuration. The bench provokes this by holding a request high across two cycles. It then checks that `done_o` is high on the very sample where RAS# is seen low again, and that the measured precharge matches the first cycle's latched setting. A change of configuration made right after a RAS# fall covers the other overlap, where the inputs change while a cycle is in progress.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  parameter int HALF_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_PRE
  } seq_state_e;

  typedef struct packed {
    logic [HALF_W-1:0] rcd_h;
    logic [HALF_W-1:0] cas_h;
    logic [HALF_W-1:0] rp_h;
    logic              refresh;
  } cyc_cfg_t;
endpackage

// File: rtl/dram_seq_arb.sv
module dram_seq_arb (
  input  logic access_req_i,
  input  logic refresh_req_i,
  output logic go_o,
  output logic pick_refresh_o
);
  assign go_o           = access_req_i | refresh_req_i;
  assign pick_refresh_o = refresh_req_i;  // refresh wins, R10
endmodule

// File: rtl/dram_seq_timing.sv
module dram_seq_timing
  import dram_seq_pkg::*;
#(
  parameter int RCD_LONG_H  = 4,
  parameter int RCD_SHORT_H = 2,
  parameter int RP_LONG_H   = 4,
  parameter int RP_MID_H    = 3,
  parameter int RP_SHORT_H  = 2,
  parameter int CAS_BASE_H  = 2
) (
  input  logic       edo_i,
  input  logic       rcd_sel_i,
  input  logic [1:0] rp_sel_i,
  input  logic       refresh_i,
  output cyc_cfg_t   cfg_o
);
  localparam logic [1:0] RP_CODE_MID = 2'b01;
  localparam logic [1:0] RP_CODE_SHORT = 2'b10;

  logic rp_mid;
  logic [HALF_W-1:0] rp_base;

  assign rp_mid = (rp_sel_i == RP_CODE_MID);

  // reserved code falls through to the long setting
  always_comb begin
    if (rp_mid)                         rp_base = HALF_W'(RP_MID_H);
    else if (rp_sel_i == RP_CODE_SHORT) rp_base = HALF_W'(RP_SHORT_H);
    else                                rp_base = HALF_W'(RP_LONG_H);
  end

  always_comb begin
    cfg_o.refresh = refresh_i;
    // EDO with 1.5-clock precharge needs the long delay for column setup
    if ((edo_i && rp_mid) || !rcd_sel_i) cfg_o.rcd_h = HALF_W'(RCD_LONG_H);
    else                                 cfg_o.rcd_h = HALF_W'(RCD_SHORT_H);
    cfg_o.cas_h = HALF_W'(CAS_BASE_H) + HALF_W'(rp_mid);
    cfg_o.rp_h  = rp_base + HALF_W'(refresh_i && !edo_i && !rp_mid);
  end
endmodule

// File: rtl/dram_seq_core.sv
module dram_seq_core
  import dram_seq_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     go_i,
  input  cyc_cfg_t cfg_i,
  output logic     ras_n_o,
  output logic     cas_n_o,
  output logic     col_sel_o,
  output logic     done_o
);
  localparam logic [HALF_W-1:0] ONE = HALF_W'(1);

  seq_state_e        state_q;
  cyc_cfg_t          cyc_q;
  logic [HALF_W-1:0] cnt_q;
  logic              ras_n_q, cas_n_q, col_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cyc_q   <= '0;
      cnt_q   <= '0;
      ras_n_q <= 1'b1;
      cas_n_q <= 1'b1;
      col_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (go_i) begin
            state_q <= ST_ROW;
            ras_n_q <= 1'b0;
            cyc_q   <= cfg_i;
            cnt_q   <= cfg_i.rcd_h - ONE;
          end
        end
        ST_ROW: begin
          if (cnt_q == '0) begin
            state_q <= ST_COL;
            cas_n_q <= cyc_q.refresh;
            cnt_q   <= cyc_q.cas_h - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
            if (cnt_q == ONE && !cyc_q.refresh) col_q <= 1'b1;
          end
        end
        ST_COL: begin
          if (cnt_q == '0) begin
            state_q <= ST_PRE;
            ras_n_q <= 1'b1;
            cas_n_q <= 1'b1;
            col_q   <= 1'b0;
            cnt_q   <= cyc_q.rp_h - ONE;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_PRE: begin
          if (cnt_q == '0) begin
            done_q <= 1'b1;
            if (go_i) begin
              state_q <= ST_ROW;
              ras_n_q <= 1'b0;
              cyc_q   <= cfg_i;
              cnt_q   <= cfg_i.rcd_h - ONE;
            end else begin
              state_q <= ST_IDLE;
            end
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ras_n_o   = ras_n_q;
  assign cas_n_o   = cas_n_q;
  assign col_sel_o = col_q;
  assign done_o    = done_q;

  AST_CAS_INSIDE_RAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_n_q |-> !ras_n_q);  // R7
  AST_STROBES_RISE_TOGETHER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n_q) |-> cas_n_q);  // R7
  AST_REFRESH_NO_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && cyc_q.refresh) |-> (cas_n_q && !col_q));  // R8
  AST_COL_LEADS_CAS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_n_q) |-> ($past(col_q) && col_q));  // R9
  AST_DONE_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);  // R12
  AST_DONE_AFTER_PRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(ras_n_q));  // R12
endmodule

// File: rtl/dram_ras_cas_seq.sv
module dram_ras_cas_seq
  import dram_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       access_req_i,
  input  logic       refresh_req_i,
  input  logic       edo_i,
  input  logic       rcd_sel_i,
  input  logic [1:0] rp_sel_i,
  output logic       ras_n_o,
  output logic       cas_n_o,
  output logic       col_sel_o,
  output logic       done_o
);
  logic     go, pick_refresh;
  cyc_cfg_t cfg;

  dram_seq_arb u_arb (
    .access_req_i  (access_req_i),
    .refresh_req_i (refresh_req_i),
    .go_o          (go),
    .pick_refresh_o(pick_refresh)
  );

  dram_seq_timing u_timing (
    .edo_i    (edo_i),
    .rcd_sel_i(rcd_sel_i),
    .rp_sel_i (rp_sel_i),
    .refresh_i(pick_refresh),
    .cfg_o    (cfg)
  );

  dram_seq_core u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go),
    .cfg_i    (cfg),
    .ras_n_o  (ras_n_o),
    .cas_n_o  (cas_n_o),
    .col_sel_o(col_sel_o),
    .done_o   (done_o)
  );
endmodule

// File: tb/dram_ras_cas_seq_tb_top.sv
module dram_ras_cas_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_req = 1'b0, ref_req = 1'b0, edo = 1'b0, rcd_sel = 1'b0;
  logic [1:0] rp_sel = 2'b00;
  logic ras_n, cas_n, col_sel, done;

  int ticks = 0;
  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;
  always @(posedge clk) ticks <= ticks + 1;

  dram_ras_cas_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .access_req_i(acc_req), .refresh_req_i(ref_req),
    .edo_i(edo), .rcd_sel_i(rcd_sel), .rp_sel_i(rp_sel),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .col_sel_o(col_sel), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_rp(input logic [1:0] rp);
    return (rp == 2'b11) ? 0 : int'(rp);
  endfunction
  function automatic int exp_rcd(input logic e, input logic s, input logic [1:0] rp);
    if (e && eff_rp(rp) == 1) return 4;
    return s ? 2 : 4;
  endfunction
  function automatic int exp_cas(input logic [1:0] rp);
    return (eff_rp(rp) == 1) ? 3 : 2;
  endfunction
  function automatic int exp_pre(input logic e, input logic [1:0] rp, input logic refr);
    int b;
    b = (eff_rp(rp) == 0) ? 4 : (eff_rp(rp) == 1) ? 3 : 2;
    if (refr && !e && eff_rp(rp) != 1) b++;
    return b;
  endfunction

  int m_rcd, m_caslen, m_raslow, m_pre;
  bit m_cas_seen, m_col_ok, m_done_ok;

  // measures one cycle plus the gap to the next RAS# fall; requests must be pending
  task automatic measure(input bit flip);
    int t_fall, t_cas, t_rise, t_next;
    bit prev_col;
    t_cas = -1; m_col_ok = 1'b1; m_cas_seen = 1'b0; prev_col = 1'b0;
    @(negedge clk);
    while (ras_n) @(negedge clk);
    t_fall = ticks;
    if (flip) begin rcd_sel = 1'b1; rp_sel = 2'b10; edo = 1'b1; end
    while (!ras_n) begin
      if (!cas_n && !m_cas_seen) begin
        m_cas_seen = 1'b1; t_cas = ticks;
        if (!prev_col || !col_sel) m_col_ok = 1'b0;
      end
      prev_col = col_sel;
      @(negedge clk);
    end
    t_rise = ticks;
    if (!cas_n || col_sel) m_col_ok = 1'b0;
    while (ras_n) @(negedge clk);
    t_next = ticks;
    m_done_ok = done;
    acc_req = 1'b0; ref_req = 1'b0;
    m_rcd = t_cas - t_fall;
    m_caslen = t_rise - t_cas;
    m_raslow = t_rise - t_fall;
    m_pre = t_next - t_rise;
  endtask

  task automatic settle();
    acc_req = 1'b0; ref_req = 1'b0;
    @(negedge clk);
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R12 idle ras", int'(ras_n), 1);
  endtask

  task automatic t_reset();
    chk("R1 ras", int'(ras_n), 1);
    chk("R1 cas", int'(cas_n), 1);
    chk("R1 col", int'(col_sel), 0);
    chk("R1 done", int'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ras idle", int'(ras_n), 1);
    chk("R1 done idle", int'(done), 0);
  endtask

  task automatic t_access(input logic e, input logic s, input logic [1:0] rp);
    edo = e; rcd_sel = s; rp_sel = rp; acc_req = 1'b1;
    measure(1'b0);
    chk((e && eff_rp(rp) == 1) ? "R3 rcd" : "R2 rcd", m_rcd, exp_rcd(e, s, rp));
    chk("R7 cas width", m_caslen, exp_cas(rp));
    chk((rp == 2'b11) ? "R5 precharge" : "R4 precharge", m_pre, exp_pre(e, rp, 1'b0));
    chk("R9 col select", int'(m_col_ok), 1);
    chk("R12 done at relaunch", int'(m_done_ok), 1);
    settle();
  endtask

  task automatic t_refresh(input logic e, input logic [1:0] rp);
    edo = e; rcd_sel = 1'b1; rp_sel = rp; ref_req = 1'b1;
    measure(1'b0);
    chk("R8 cas high", int'(m_cas_seen), 0);
    chk("R8 col low", int'(m_col_ok), 1);
    chk("R8 ras low", m_raslow, exp_rcd(e, 1'b1, rp) + exp_cas(rp));
    chk("R6 refresh precharge", m_pre, exp_pre(e, rp, 1'b1));
    settle();
  endtask

  task automatic t_priority();
    edo = 1'b0; rcd_sel = 1'b0; rp_sel = 2'b00; acc_req = 1'b1; ref_req = 1'b1;
    measure(1'b0);
    chk("R10 refresh first", int'(m_cas_seen), 0);
    chk("R10 refresh precharge", m_pre, 5);
    settle();
  endtask

  task automatic t_midchange();
    edo = 1'b0; rcd_sel = 1'b0; rp_sel = 2'b00; acc_req = 1'b1;
    measure(1'b1);
    chk("R11 rcd held", m_rcd, 4);
    chk("R11 cas held", m_caslen, 2);
    chk("R11 precharge held", m_pre, 4);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 2; s++)
        for (int rp = 0; rp < 4; rp++)
          t_access(e[0], s[0], rp[1:0]);
    for (int e = 0; e < 2; e++)
      for (int rp = 0; rp < 4; rp++)
        t_refresh(e[0], rp[1:0]);
    t_priority();
    t_midchange();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #400000;
    n_checks++;
    n_errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", ticks, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule